// File: doc/BRIEF.md
# Two-Phase Fetch-Execute Sequencer

This block is the control core of a small load/store processor whose instructions are all one 32-bit word long. It keeps a program counter and an instruction register. For every instruction it reads the word at the program counter into the instruction register, then decodes and carries it out. Carrying it out can mean an ALU write-back, a data read or write, or a change of the program counter. A small register file of signed two's-complement values lives inside the block.

The block talks to a word memory through registered address, read-strobe, write-strobe and write-data outputs. The memory answers a read on the cycle after the strobe, as a synchronous block RAM does. An instruction takes three cycles if it touches no data (fetch, fetch-wait, execute). A store takes four and a load takes five. An opcode outside the defined set stops the sequencer and raises a sticky error.

Top module: `fx_sequencer`

## Requirements
- R1: After synchronous reset the program counter equals START_ADDR, `err` is 0, and the first cycle after reset is a fetch: `mem_rd`=1 with `mem_addr`=START_ADDR.
- R2: A fetch cycle drives `mem_rd`=1 with `mem_addr` equal to `pc`. The word returned on the next cycle becomes the instruction, and the execute cycle follows. Instruction fields: opcode [31:28], register A [27:24], register B [23:20], register C [19:16], 16-bit immediate [15:0].
- R3: `pc` advances by 4 at the end of the execute cycle of every instruction except a taken branch.
- R4: Opcode 3 writes B+C into A. A may name the same register as B or C, and the sources are read before the write.
- R5: Opcode 4 writes B plus the sign-extended immediate into A. Opcode 5 writes B minus the sign-extended immediate into A.
- R6: Opcode 1 reads the word at B plus the sign-extended immediate and writes it into A. This takes one read strobe and one wait cycle.
- R7: Opcode 2 writes register A to address B plus the sign-extended immediate. `mem_wr` is high for exactly one cycle.
- R8: Opcode 6 branches to the target {imm[15:2],2'b00} only when A holds a signed value strictly greater than zero. When A is zero or negative, execution falls through to `pc`+4.
- R9: Opcode 7 branches to the same target when A is greater than B under signed comparison. It leaves both A and B unchanged, and equal values do not branch.
- R10: Opcode 0 and opcodes 8 to 15 set `err`, which then stays set. No further memory strobes follow, and `pc` keeps the address of the offending word.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Read strobe, data expected the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_wdata | output | DATA_W | Data to write |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_rd` |
| pc | output | ADDR_W | Current program counter |
| err | output | 1 | Sticky illegal-opcode flag; sequencer halted |

## Verification
The test program mixes several patterns. Back-to-back register arithmetic, including a destination that is also a source, separates reading before writing from reading after writing. A countdown loop exercises both the taken and the fall-through cases of the greater-than-zero branch. Comparisons of a negative against a positive value, and of a value against itself, separate signed from unsigned comparison and strict from non-strict comparison. A load that reads back a freshly stored word shows that the write and read paths use the same addressing. Every cycle's strobes, address, write data, program counter and error flag are compared against a behavioural instruction-level model. Words stored from registers show, through the memory, that the compared and skipped registers were left alone.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int INSTR_W = 32;
  localparam int FLD_W   = 4;
  localparam int OP_LSB  = 28;
  localparam int RA_LSB  = 24;
  localparam int RB_LSB  = 20;
  localparam int RC_LSB  = 16;
  localparam int IMM_W   = 16;

  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd3;
  localparam logic [3:0] OPC_ADDI  = 4'd4;
  localparam logic [3:0] OPC_SUBI  = 4'd5;
  localparam logic [3:0] OPC_BGTZ  = 4'd6;
  localparam logic [3:0] OPC_BGT   = 4'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_EXEC, ST_MRD, ST_MWAIT, ST_MWR, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    K_WRITE, K_LOAD, K_STORE, K_JUMP, K_BAD
  } exec_kind_e;
endpackage

// File: rtl/fx_regfile.sv
module fx_regfile #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr_a,
  input  logic [RA_W-1:0]   raddr_b,
  input  logic [RA_W-1:0]   raddr_c,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_c
);
  logic [DATA_W-1:0] cells [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[g] <= '0;
      end else if (we && (waddr == RA_W'(g))) begin
        cells[g] <= wdata;
      end
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
  assign rdata_c = cells[raddr_c];
endmodule

// File: rtl/fx_exec_unit.sv
module fx_exec_unit
  import fx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic [3:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] va,
  input  logic [DATA_W-1:0] vb,
  input  logic [DATA_W-1:0] vc,
  output exec_kind_e        kind,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] next_pc
);
  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] sum_bi;
  logic [DATA_W-1:0] dif_bi;
  logic [ADDR_W-1:0] seq_pc;
  logic [IMM_W-1:0]  tgt_full;
  logic              a_pos;
  logic              a_gt_b;

  assign imm_sx   = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign sum_bi   = vb + imm_sx;
  assign dif_bi   = vb - imm_sx;
  assign seq_pc   = pc + ADDR_W'(4);
  assign tgt_full = {imm[IMM_W-1:2], 2'b00};
  assign a_pos    = ($signed(va) > 0);
  assign a_gt_b   = ($signed(va) > $signed(vb));
  assign ea       = sum_bi[ADDR_W-1:0];

  always_comb begin
    kind    = K_BAD;
    result  = '0;
    next_pc = seq_pc;
    unique case (op)
      OPC_LOAD:  kind = K_LOAD;
      OPC_STORE: kind = K_STORE;
      OPC_ADD: begin
        kind   = K_WRITE;
        result = vb + vc;
      end
      OPC_ADDI: begin
        kind   = K_WRITE;
        result = sum_bi;
      end
      OPC_SUBI: begin
        kind   = K_WRITE;
        result = dif_bi;
      end
      OPC_BGTZ: begin
        kind = K_JUMP;
        if (a_pos) next_pc = tgt_full[ADDR_W-1:0];
      end
      OPC_BGT: begin
        kind = K_JUMP;
        if (a_gt_b) next_pc = tgt_full[ADDR_W-1:0];
      end
      default: begin
        kind    = K_BAD;
        next_pc = pc;
      end
    endcase
  end
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fx_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 16,
  parameter int              NREGS      = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic              err
);
  localparam int RA_W = $clog2(NREGS);

  seq_state_e          state;
  logic [INSTR_W-1:0]  ir;
  exec_kind_e          kind;
  logic [DATA_W-1:0]   va, vb, vc;
  logic [DATA_W-1:0]   alu_res;
  logic [ADDR_W-1:0]   ea;
  logic [ADDR_W-1:0]   next_pc;
  logic                rf_we;
  logic [DATA_W-1:0]   rf_wdata;
  logic                fetch_phase;

  assign fetch_phase = (state == ST_FETCH);
  assign rf_we    = ((state == ST_EXEC) && (kind == K_WRITE)) || (state == ST_MWAIT);
  assign rf_wdata = (state == ST_MWAIT) ? mem_rdata : alu_res;

  fx_regfile #(
    .NREGS (NREGS),
    .DATA_W(DATA_W),
    .RA_W  (RA_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (ir[RA_LSB +: RA_W]),
    .wdata  (rf_wdata),
    .raddr_a(ir[RA_LSB +: RA_W]),
    .raddr_b(ir[RB_LSB +: RA_W]),
    .raddr_c(ir[RC_LSB +: RA_W]),
    .rdata_a(va),
    .rdata_b(vb),
    .rdata_c(vc)
  );

  fx_exec_unit #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_exec (
    .op     (ir[OP_LSB +: FLD_W]),
    .imm    (ir[IMM_W-1:0]),
    .pc     (pc),
    .va     (va),
    .vb     (vb),
    .vc     (vc),
    .kind   (kind),
    .result (alu_res),
    .ea     (ea),
    .next_pc(next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= START_ADDR;
      ir        <= '0;
      err       <= 1'b0;
      mem_rd    <= 1'b1;
      mem_wr    <= 1'b0;
      mem_addr  <= START_ADDR;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          mem_rd <= 1'b0;
          state  <= ST_FWAIT;
        end
        ST_FWAIT: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (kind)
            K_WRITE, K_JUMP: begin
              pc       <= next_pc;
              mem_rd   <= 1'b1;
              mem_addr <= next_pc;
              state    <= ST_FETCH;
            end
            K_LOAD: begin
              pc       <= next_pc;
              mem_rd   <= 1'b1;
              mem_addr <= ea;
              state    <= ST_MRD;
            end
            K_STORE: begin
              pc        <= next_pc;
              mem_wr    <= 1'b1;
              mem_addr  <= ea;
              mem_wdata <= va;
              state     <= ST_MWR;
            end
            default: begin
              err   <= 1'b1;
              state <= ST_HALT;
            end
          endcase
        end
        ST_MRD: begin
          mem_rd <= 1'b0;
          state  <= ST_MWAIT;
        end
        ST_MWAIT: begin
          mem_rd   <= 1'b1;
          mem_addr <= pc;
          state    <= ST_FETCH;
        end
        ST_MWR: begin
          mem_wr   <= 1'b0;
          mem_rd   <= 1'b1;
          mem_addr <= pc;
          state    <= ST_FETCH;
        end
        default: begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
          state  <= ST_HALT;
        end
      endcase
    end
  end
endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic              err,
  input logic              in_fetch
);
  AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == START && mem_rd && mem_addr == START && !err)); // R1
  AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    in_fetch |-> (mem_rd && mem_addr == pc)); // R2
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (pc[1:0] == START[1:0])); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && $stable(pc))); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_rd && !mem_wr)); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11
endmodule

bind fx_sequencer fx_sequencer_chk #(
  .ADDR_W(ADDR_W),
  .START (START_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .mem_addr(mem_addr),
  .pc      (pc),
  .err     (err),
  .in_fetch(fetch_phase)
);

// File: tb/test_fx_sequencer.sv
`timescale 1ns/1ps
module test_fx_sequencer;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int WORDS = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_rd, mem_wr, err;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem  [WORDS];
  logic [DW-1:0] mmem [WORDS];

  int n_checks = 0;
  int n_errors = 0;

  bit    q_rd[$], q_wr[$], q_err[$];
  int    q_addr[$], q_wdata[$], q_pc[$];
  string q_tag[$];

  always #2 clk = ~clk;

  fx_sequencer #(.DATA_W(DW), .ADDR_W(AW), .NREGS(16), .START_ADDR('0)) i_fx_sequencer (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .err(err)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[8:2]];
    if (mem_wr) mem[mem_addr[8:2]] <= mem_wdata;
  end

  function automatic logic [31:0] enc(input int op, input int a, input int b, input int c, input int imm);
    logic [31:0] w;
    w = {op[3:0], a[3:0], b[3:0], c[3:0], imm[15:0]};
    return w;
  endfunction

  task automatic push(input bit rd, input bit wr, input int addr, input int wdata,
                      input int pcv, input bit e, input string tag);
    q_rd.push_back(rd); q_wr.push_back(wr); q_addr.push_back(addr);
    q_wdata.push_back(wdata); q_pc.push_back(pcv); q_err.push_back(e); q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Instruction-level reference: builds the expected bus trace cycle by cycle.
  task automatic run_model();
    int rf[16];
    int p = 0;
    bit halted = 0;
    int steps = 0;
    foreach (rf[i]) rf[i] = 0;
    while (!halted && steps < 300) begin
      logic [31:0] w;
      int op, a, b, c, imm, ea, nxt;
      steps++;
      w   = mmem[p >> 2];
      op  = int'(w[31:28]);
      a   = int'(w[27:24]);
      b   = int'(w[23:20]);
      c   = int'(w[19:16]);
      imm = $signed(w[15:0]);
      ea  = (rf[b] + imm) & 16'hFFFF;
      nxt = (p + 4) & 16'hFFFF;
      push(1, 0, p, 0, p, 0, (steps == 1) ? "R1 first fetch" : "R2 fetch");
      push(0, 0, 0, 0, p, 0, "R2 fetch wait");
      push(0, 0, 0, 0, p, 0, "R2 execute");
      case (op)
        1: begin
          push(1, 0, ea, 0, nxt, 0, "R6 load read");
          push(0, 0, 0, 0, nxt, 0, "R6 load wait");
          rf[a] = int'(mmem[ea >> 2]);
        end
        2: begin
          push(0, 1, ea, rf[a], nxt, 0, "R7 store");
          mmem[ea >> 2] = rf[a];
        end
        3: rf[a] = rf[b] + rf[c];
        4: rf[a] = rf[b] + imm;
        5: rf[a] = rf[b] - imm;
        6: if (rf[a] > 0) nxt = int'(w[15:0]) & 16'hFFFC;
        7: if (rf[a] > rf[b]) nxt = int'(w[15:0]) & 16'hFFFC;
        default: begin
          halted = 1;
          nxt = p;
          for (int k = 0; k < 12; k++) push(0, 0, 0, 0, p, 1, "R10 halted");
        end
      endcase
      p = nxt;
    end
  endtask

  initial begin
    foreach (mem[i]) mem[i] = '0;
    mem[0]  = enc(4, 1, 0, 0, 5);        // r1 = 5
    mem[1]  = enc(4, 2, 0, 0, -3);       // r2 = -3
    mem[2]  = enc(1, 3, 0, 0, 'h100);    // r3 = M[0x100] = 7
    mem[3]  = enc(3, 4, 1, 3, 0);        // r4 = 12
    mem[4]  = enc(3, 1, 1, 1, 0);        // r1 = 10
    mem[5]  = enc(4, 6, 0, 0, 3);        // r6 = 3
    mem[6]  = enc(3, 7, 7, 1, 0);        // loop: r7 += r1
    mem[7]  = enc(5, 6, 6, 0, 1);        // r6 -= 1
    mem[8]  = enc(6, 6, 0, 0, 'h18);     // r6 > 0 -> loop
    mem[9]  = enc(6, 2, 0, 0, 'h00);     // negative: fall through
    mem[10] = enc(7, 2, 1, 0, 'h00);     // -3 > 10 signed: fall through
    mem[11] = enc(7, 1, 2, 0, 'h38);     // 10 > -3: taken
    mem[12] = enc(4, 8, 0, 0, 99);       // skipped
    mem[13] = enc(4, 8, 0, 0, 98);       // skipped
    mem[14] = enc(7, 1, 1, 0, 'h00);     // equal: fall through
    mem[15] = enc(2, 4, 0, 0, 'h104);
    mem[16] = enc(2, 7, 0, 0, 'h108);
    mem[17] = enc(2, 1, 0, 0, 'h10C);
    mem[18] = enc(2, 2, 0, 0, 'h110);
    mem[19] = enc(2, 8, 0, 0, 'h114);
    mem[20] = enc(5, 9, 2, 0, -5);       // r9 = -3 - (-5) = 2
    mem[21] = enc(2, 9, 0, 0, 'h118);
    mem[22] = enc(1, 10, 0, 0, 'h104);   // read back stored 12
    mem[23] = enc(3, 11, 10, 3, 0);      // r11 = 19
    mem[24] = enc(2, 11, 0, 0, 'h11C);
    mem[25] = 32'hF000_0000;             // undefined opcode
    mem[64] = 32'd7;
    foreach (mmem[i]) mmem[i] = mem[i];
    run_model();

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check(pc == '0, "R1 reset pc", int'(pc), 0);
    check(mem_rd && mem_addr == '0, "R1 reset fetch strobe", int'(mem_rd), 1);
    check(!err, "R1 reset err", int'(err), 0);

    foreach (q_tag[i]) begin
      bit ok;
      ok = (mem_rd == q_rd[i]) && (mem_wr == q_wr[i]) && (err == q_err[i]) &&
           (int'(pc) == q_pc[i]) && !(mem_rd && mem_wr);
      if ((q_rd[i] || q_wr[i]) && int'(mem_addr) != q_addr[i]) ok = 0;
      if (q_wr[i] && int'(mem_wdata) != q_wdata[i]) ok = 0;
      check(ok, $sformatf("%s cycle %0d rd/wr/err/pc/addr", q_tag[i], i),
            int'({mem_rd, mem_wr, err, pc, mem_addr}),
            int'({q_rd[i], q_wr[i], q_err[i], q_pc[i][15:0], q_addr[i][15:0]}));
      @(negedge clk);
    end

    check(mem[65] == 32'd12, "R4 add result stored", int'(mem[65]), 12);
    check(mem[66] == 32'd30, "R8 loop ran three times", int'(mem[66]), 30);
    check(mem[67] == 32'd10, "R9 first compared reg unchanged", int'(mem[67]), 10);
    check(mem[68] == 32'hFFFF_FFFD, "R9 second compared reg unchanged", int'(mem[68]), -3);
    check(mem[69] == 32'd0, "R9 taken branch skipped writes", int'(mem[69]), 0);
    check(mem[70] == 32'd2, "R5 subtract negative immediate", int'(mem[70]), 2);
    check(mem[71] == 32'd19, "R6 load after store", int'(mem[71]), 19);
    check(err && pc == 16'h0064, "R10 halted at bad word", int'(pc), 'h64);
    check(!mem_rd && !mem_wr, "R11 no strobes when halted", int'({mem_rd, mem_wr}), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule